// File: doc/BRIEF.md
# Headphone amplifier control register port (I2C target)

This block is the serial control port of a stereo headphone amplifier. An external I2C controller addresses it at a fixed 7-bit address and reads or writes a small bank of 8-bit registers. The registers drive the amplifier's enable, standby, mute, volume and output-float controls as parallel outputs. They also report a sticky thermal-event flag and a read-only identity byte.

A register pointer selects which register is accessed. The first byte of every write transfer loads the pointer. The pointer keeps its value between transfers, so a read transfer that follows returns data from where the pointer already stands. Each byte moved advances the pointer. SCL and SDA are synchronised to the fast system clock and filtered against short glitches before any edge is detected. SDA is driven through an open-drain pull-down enable.

Top module: `hpamp_i2c_regs`

## Requirements
- R1: The block acknowledges only the 7-bit address 1100000. The bit after the address selects the direction: 0 is a write and 1 is a read. A transfer to any other address gets no acknowledge, and SDA is left released.
- R2: In a write transfer, the first byte after the address is loaded into the pointer and acknowledged. Each further byte is acknowledged and written to the register the pointer selects, and the pointer then advances by one.
- R3: The pointer is kept across transfers. A read transfer returns data starting at the current pointer. The pointer advances by one after each read byte that the controller acknowledges. A read of an unmapped pointer value returns 0x00. A write to an unmapped pointer value is acknowledged and has no effect.
- R4: A controller NACK after a read byte ends the read. SDA stays released until the next START or STOP, and the pointer is not advanced by the NACKed byte.
- R5: Register 0x01 bits are: bit 7 left enable, bit 6 right enable, bit 0 standby. Register 0x02 bits are: bit 7 left mute, bit 6 right mute, bits 5:1 volume. Register 0x03 bits are: bit 1 left float, bit 0 right float. After reset, standby and both mutes are 1 and every other control is 0. Each control appears on its own output port.
- R6: Register 0x04 is read-only. It reads as {vendor_id[1:0], 2'b00, chip_rev[3:0]} taken from the input ports.
- R7: Reserved bits read as 0 and ignore writes. These are register 0x01 bits 5:2, register 0x02 bit 0 and register 0x03 bits 7:2. Register 0x01 bit 1 is a read-only flag, and writes to it are ignored.
- R8: Register 0x01 bit 1 is the thermal flag. It sets while fault_in is high and standby is 0, and it is never set while in standby. Once set, it stays 1 until a read of register 0x01 happens while fault_in is low. That read still returns 1, and the flag reads 0 afterwards.
- R9: A pulse on SCL or SDA shorter than FILT_HOLD system clocks (64 ns by default) has no effect on the protocol.
- R10: SDA drive changes only while SCL is low. START and STOP are recognised only as SDA edges while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| fault_in | input | 1 | Thermal fault condition present |
| chip_rev | input | 4 | Silicon revision reported in register 0x04 |
| vendor_id | input | 2 | Supplier identity reported in register 0x04 |
| amp_en_l | output | 1 | Left amplifier enable |
| amp_en_r | output | 1 | Right amplifier enable |
| stby | output | 1 | Low-power standby |
| mute_l | output | 1 | Left mute |
| mute_r | output | 1 | Right mute |
| vol | output | 5 | Volume code |
| hiz_l | output | 1 | Left output floated |
| hiz_r | output | 1 | Right output floated |

## Verification
The transfers exercised are a foreign address, single-byte and three-byte writes, reads that rely on a stored pointer, and a pointer set followed by a repeated START and a burst read. Together these separate pointer loading from pointer advance and from the rule that a NACKed byte does not advance the pointer. Data patterns with every bit set distinguish reserved and read-only bits from writable ones. The thermal sequence reads the flag before and after the fault clears, and also while in standby, which distinguishes clear-on-read from a sticky hold. A write in which every SCL low phase carries a short high glitch shows whether the filter suppresses false clock edges.

// File: rtl/hpamp_pkg.sv
package hpamp_pkg;
  localparam int VOL_W = 5;
  localparam logic [7:0] REG_PWR = 8'h01;
  localparam logic [7:0] REG_VOL = 8'h02;
  localparam logic [7:0] REG_OUT = 8'h03;
  localparam logic [7:0] REG_IDN = 8'h04;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK
  } link_st_t;
endpackage

// File: rtl/hpamp_line_filter.sv
module hpamp_line_filter #(
  parameter int SYNC = 2,
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(HOLD + 1);

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      dout   <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], din};
      if (sync_q[SYNC-1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(HOLD - 1)) begin
        dout  <= sync_q[SYNC-1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hpamp_i2c_link.sv
module hpamp_i2c_link
  import hpamp_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl,
  input  logic       sda,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic [7:0] ptr,
  output logic       ptr_ld,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       rd_stb
);
  link_st_t   st;
  logic       scl_q, sda_q, rw, have_ptr, macked;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rise, fall, start_c, stop_c, byte_done;

  always_comb begin
    rise      = scl & ~scl_q;
    fall      = ~scl & scl_q;
    start_c   = scl & scl_q & sda_q & ~sda;
    stop_c    = scl & scl_q & ~sda_q & sda;
    byte_done = fall && (cnt == 4'd8);
    ptr_ld    = (st == S_WR) && byte_done && !have_ptr && !start_c && !stop_c;
    wr_en     = (st == S_WR) && byte_done && have_ptr && !start_c && !stop_c;
    wr_data   = sh;
    rd_stb    = ((st == S_AACK) && fall && rw) || ((st == S_RACK) && fall && macked);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; rw <= 1'b0;
      have_ptr <= 1'b0; macked <= 1'b0; cnt <= '0; sh <= '0;
      ptr <= '0; sda_pull <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (rise) begin
              sh <= {sh[6:0], sda}; cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              if (sh[7:1] == SLAVE_ADDR) begin
                sda_pull <= 1'b1; rw <= sh[0]; st <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (fall) begin
            cnt <= '0;
            if (rw) begin
              sh <= rd_data; sda_pull <= ~rd_data[7]; st <= S_RD;
            end else begin
              sda_pull <= 1'b0; have_ptr <= 1'b0; st <= S_WR;
            end
          end
          S_WR: begin
            if (rise) begin
              sh <= {sh[6:0], sda}; cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              sda_pull <= 1'b1; st <= S_WACK;
              if (!have_ptr) begin
                ptr <= sh; have_ptr <= 1'b1;
              end else begin
                ptr <= ptr + 8'd1;
              end
            end
          end
          S_WACK: if (fall) begin
            sda_pull <= 1'b0; cnt <= '0; st <= S_WR;
          end
          S_RD: begin
            if (rise) begin
              cnt <= cnt + 1'b1;
            end else if (fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0; cnt <= '0; st <= S_RACK;
              end else begin
                sda_pull <= ~sh[6]; sh <= {sh[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (rise) begin
              macked <= ~sda;
              if (!sda) ptr <= ptr + 8'd1;
            end else if (fall) begin
              if (macked) begin
                sh <= rd_data; sda_pull <= ~rd_data[7]; cnt <= '0; st <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hpamp_regbank.sv
module hpamp_regbank
  import hpamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_stb,
  input  logic             fault_in,
  input  logic [3:0]       chip_rev,
  input  logic [1:0]       vendor_id,
  output logic [7:0]       rd_data,
  output logic             therm_flag,
  output logic             amp_en_l,
  output logic             amp_en_r,
  output logic             stby,
  output logic             mute_l,
  output logic             mute_r,
  output logic [VOL_W-1:0] vol,
  output logic             hiz_l,
  output logic             hiz_r
);
  logic therm_set, therm_clr;

  always_comb begin
    therm_set = fault_in && !stby;
    therm_clr = rd_stb && (addr == REG_PWR) && !fault_in;
    case (addr)
      REG_PWR: rd_data = {amp_en_l, amp_en_r, 4'b0000, therm_flag, stby};
      REG_VOL: rd_data = {mute_l, mute_r, vol, 1'b0};
      REG_OUT: rd_data = {6'b000000, hiz_l, hiz_r};
      REG_IDN: rd_data = {vendor_id, 2'b00, chip_rev};
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en_l <= 1'b0; amp_en_r <= 1'b0; stby <= 1'b1;
      mute_l <= 1'b1; mute_r <= 1'b1; vol <= '0;
      hiz_l <= 1'b0; hiz_r <= 1'b0; therm_flag <= 1'b0;
    end else begin
      therm_flag <= therm_set | (therm_flag & ~therm_clr);
      if (wr_en) begin
        case (addr)
          REG_PWR: begin
            amp_en_l <= wr_data[7]; amp_en_r <= wr_data[6]; stby <= wr_data[0];
          end
          REG_VOL: begin
            mute_l <= wr_data[7]; mute_r <= wr_data[6]; vol <= wr_data[5:1];
          end
          REG_OUT: begin
            hiz_l <= wr_data[1]; hiz_r <= wr_data[0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hpamp_i2c_regs.sv
module hpamp_i2c_regs
  import hpamp_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b1100000,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_HOLD   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic             fault_in,
  input  logic [3:0]       chip_rev,
  input  logic [1:0]       vendor_id,
  output logic             amp_en_l,
  output logic             amp_en_r,
  output logic             stby,
  output logic             mute_l,
  output logic             mute_r,
  output logic [VOL_W-1:0] vol,
  output logic             hiz_l,
  output logic             hiz_r
);
  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic [7:0] ptr, wr_data, rd_data;
  logic       ptr_ld, wr_en, rd_stb, therm_flag;

  assign raw_lines = {scl_in, sda_in};
  assign scl_f     = filt_lines[1];
  assign sda_f     = filt_lines[0];

  for (genvar g = 0; g < 2; g++) begin : g_line
    hpamp_line_filter #(.SYNC(SYNC_STAGES), .HOLD(FILT_HOLD)) u_filt (
      .clk(clk), .rst(rst), .din(raw_lines[g]), .dout(filt_lines[g])
    );
  end

  hpamp_i2c_link #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f), .rd_data(rd_data),
    .sda_pull(sda_pull), .ptr(ptr), .ptr_ld(ptr_ld), .wr_en(wr_en),
    .wr_data(wr_data), .rd_stb(rd_stb)
  );

  hpamp_regbank u_regs (
    .clk(clk), .rst(rst), .addr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_stb(rd_stb), .fault_in(fault_in), .chip_rev(chip_rev),
    .vendor_id(vendor_id), .rd_data(rd_data), .therm_flag(therm_flag),
    .amp_en_l(amp_en_l), .amp_en_r(amp_en_r), .stby(stby),
    .mute_l(mute_l), .mute_r(mute_r), .vol(vol),
    .hiz_l(hiz_l), .hiz_r(hiz_r)
  );
endmodule

// File: rtl/hpamp_i2c_regs_chk.sv
module hpamp_i2c_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       sda_pull,
  input logic [7:0] ptr,
  input logic       ptr_ld,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       therm_flag,
  input logic       fault_in,
  input logic       stby
);
  // R10: drive changes only while the filtered clock is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !scl_f);

  // R2/R3: pointer moves only by a load or a single step
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    !ptr_ld |=> (ptr == $past(ptr) || ptr == $past(ptr) + 8'd1));

  a_r7_reserved_pwr: assert property (@(posedge clk) disable iff (rst)
    (ptr == 8'h01) |-> (rd_data[5:2] == 4'd0));

  a_r7_reserved_out: assert property (@(posedge clk) disable iff (rst)
    (ptr == 8'h03) |-> (rd_data[7:2] == 6'd0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (therm_flag && !rd_stb) |=> therm_flag);

  a_r8_hold_in_fault: assert property (@(posedge clk) disable iff (rst)
    (therm_flag && fault_in) |=> therm_flag);

  a_r5_reset_stby: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> stby);
endmodule

bind hpamp_i2c_regs hpamp_i2c_regs_chk u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_pull(sda_pull), .ptr(ptr),
  .ptr_ld(ptr_ld), .rd_stb(rd_stb), .rd_data(rd_data),
  .therm_flag(therm_flag), .fault_in(fault_in), .stby(stby)
);

// File: tb/test_hpamp_i2c_regs.sv
`timescale 1ns/1ps
module test_hpamp_i2c_regs;
  localparam int Q = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, fault = 1'b0;
  logic [3:0] chip_rev = 4'b0101;
  logic [1:0] vendor_id = 2'b00;
  logic sda_pull, amp_en_l, amp_en_r, stby, mute_l, mute_r, hiz_l, hiz_r;
  logic [4:0] vol;
  wire sda_line = sda_m & ~sda_pull;

  int total = 0, fails = 0, mism = 0, drv_bad = 0;
  bit busy = 1'b1, done = 1'b0;

  // behavioural model of control fields
  bit m_enl = 0, m_enr = 0, m_stby = 1, m_mutel = 1, m_muter = 1, m_hizl = 0, m_hizr = 0;
  int m_vol = 0;

  always #2 clk = ~clk;

  hpamp_i2c_regs i_hpamp_i2c_regs (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .fault_in(fault), .chip_rev(chip_rev), .vendor_id(vendor_id),
    .amp_en_l(amp_en_l), .amp_en_r(amp_en_r), .stby(stby), .mute_l(mute_l),
    .mute_r(mute_r), .vol(vol), .hiz_l(hiz_l), .hiz_r(hiz_r)
  );

  logic prev_pull = 1'b0;
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (sda_pull != prev_pull && scl_m) drv_bad++;
      if (!busy && ({amp_en_l, amp_en_r, stby, mute_l, mute_r, vol, hiz_l, hiz_r} !=
          {m_enl, m_enr, m_stby, m_mutel, m_muter, 5'(m_vol), m_hizl, m_hizr})) mism++;
    end
    prev_pull = sda_pull;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input int a, input logic [7:0] d);
    case (a)
      1: begin m_enl = d[7]; m_enr = d[6]; m_stby = d[0]; end
      2: begin m_mutel = d[7]; m_muter = d[6]; m_vol = int'(d[5:1]); end
      3: begin m_hizl = d[1]; m_hizr = d[0]; end
      default: ;
    endcase
  endfunction

  task automatic i2c_start();
    if (scl_m) begin
      sda_m = 1'b0; w(2*Q); scl_m = 1'b0;
    end else begin
      w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl_m = 1'b0;
    end
  endtask

  task automatic i2c_stop();
    w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic clk_bit(input logic b, input bit gl, output logic s);
    w(Q); sda_m = b;
    if (gl) begin w(4); scl_m = 1'b1; w(10); scl_m = 1'b0; w(Q-14); end
    else w(Q);
    scl_m = 1'b1; w(Q); s = sda_line; w(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], gl, s);
    clk_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 1'b0, s); d[i] = s; end
    clk_bit(!mack, 1'b0, s);
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n, input logic [23:0] d,
                        input bit gl, input string tag);
    bit ack;
    busy = 1'b1;
    i2c_start();
    send_byte(8'hC0, gl, ack); chk({tag, " R1 address ack"}, ack, 1);
    send_byte(p, gl, ack);     chk({tag, " R2 pointer ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[8*i +: 8], gl, ack); chk({tag, " R2 data ack"}, ack, 1);
    end
    i2c_stop();
    for (int i = 0; i < n; i++) model_wr(int'(p) + i, d[8*i +: 8]);
    busy = 1'b0;
  endtask

  task automatic rd_txn(input bit setp, input logic [7:0] p, input int n,
                        output logic [23:0] got);
    bit ack;
    logic [7:0] b;
    busy = 1'b1;
    got = '0;
    i2c_start();
    if (setp) begin
      send_byte(8'hC0, 1'b0, ack); chk("R1 write address ack", ack, 1);
      send_byte(p, 1'b0, ack);     chk("R2 pointer ack", ack, 1);
      i2c_start();
    end
    send_byte(8'hC1, 1'b0, ack); chk("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, b); got[8*i +: 8] = b;
    end
    i2c_stop();
    busy = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [23:0] g;
    bit ack;
    w(5); rst = 1'b0; w(40);
    busy = 1'b0;
    // R5 reset values
    chk("R5 reset fields", {amp_en_l, amp_en_r, stby, mute_l, mute_r, vol, hiz_l, hiz_r},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0});
    chk("R5 reset sda released", sda_pull, 0);

    // R1 foreign address gets no ack
    busy = 1'b1;
    i2c_start(); send_byte(8'hC2, 1'b0, ack); i2c_stop();
    chk("R1 foreign address nack", ack, 0);
    chk("R1 sda released after foreign", sda_pull, 0);
    busy = 1'b0;

    // R2 R7 single write then readback
    wr_txn(8'h02, 1, 24'h0000FF, 1'b0, "vol");
    chk("R5 volume field", vol, 31);
    rd_txn(1'b1, 8'h02, 1, g);
    chk("R7 reg2 bit0 reads 0", g[7:0], 8'hFE);

    // R2 burst write with auto increment, R7 reserved/read-only bits
    wr_txn(8'h01, 3, 24'hFF_6A_FE, 1'b0, "burst");
    chk("R2 burst vol", vol, 21);
    chk("R2 burst float", {hiz_l, hiz_r}, 2'b11);

    // R6 R3: pointer now 4, read without pointer byte
    rd_txn(1'b0, 8'h00, 1, g);
    chk("R6 id register", g[7:0], 8'h05);
    chk("R4 sda released after nack", sda_pull, 0);
    rd_txn(1'b0, 8'h00, 1, g);
    chk("R4 nacked byte not advanced", g[7:0], 8'h05);

    // R3 set pointer, repeated start, burst read
    rd_txn(1'b1, 8'h01, 3, g);
    chk("R7 reg1 read", g[7:0], 8'hC0);
    chk("R3 burst reg2", g[15:8], 8'h6A);
    chk("R7 reg3 read", g[23:16], 8'h03);
    rd_txn(1'b0, 8'h00, 1, g);
    chk("R3 pointer persisted", g[7:0], 8'h03);

    // R3 unmapped
    wr_txn(8'h10, 1, 24'h000055, 1'b0, "unmapped");
    rd_txn(1'b1, 8'h00, 1, g);
    chk("R3 unmapped read zero", g[7:0], 8'h00);

    // R8 thermal flag
    fault = 1'b1; w(20);
    rd_txn(1'b1, 8'h01, 1, g);
    chk("R8 flag set", g[7:0], 8'hC2);
    rd_txn(1'b0, 8'h00, 1, g);
    chk("R8 held under fault", g[7:0], 8'hC2);
    fault = 1'b0; w(5);
    rd_txn(1'b0, 8'h00, 1, g);
    chk("R8 read after fault clears", g[7:0], 8'hC2);
    rd_txn(1'b0, 8'h00, 1, g);
    chk("R8 flag cleared", g[7:0], 8'hC0);
    wr_txn(8'h01, 1, 24'h0000C1, 1'b0, "stby");
    fault = 1'b1; w(20); fault = 1'b0; w(5);
    rd_txn(1'b1, 8'h01, 1, g);
    chk("R8 not set in standby", g[7:0], 8'hC1);

    // R9 glitches on SCL in every low phase
    wr_txn(8'h02, 1, 24'h00003C, 1'b1, "glitch");
    chk("R9 glitch write vol", vol, 30);
    rd_txn(1'b1, 8'h02, 1, g);
    chk("R9 glitch readback", g[7:0], 8'h3C);

    w(20);
    chk("R5 fields matched model each idle clock", mism, 0);
    chk("R10 drive changed only with SCL low", drv_bad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule